// File: doc/BRIEF.md
# Key-Guarded Byte Store Controller

This block is a register-mapped controller for a small nonvolatile byte memory, modelled here as an internal array. A CPU reaches it through a simple register bus with four locations: an address register, a data register, a control/status register and a write-only key register. A read is requested through the control register and its result lands in the data register on the next clock edge, with no wait states.

A program cycle is guarded twice. A write-enable bit must already be 1 in the control register, and the key register must have received 0x55 and then 0xAA as the two bus accesses that come just before the control write that sets the start bit. Any other access in between cancels the key. Once it starts, a program cycle holds a busy bit for a fixed, parameterised number of clocks, using the address and data captured at the start. At the end it stores the byte, drops busy and raises a sticky completion flag that software must clear.

Top module: `keyed_nvm_ctrl`

## Requirements
- R1: After synchronous reset the address, data and control registers read 0x00 and `done_irq` is 0. Register selects are 0 address, 1 data, 2 control, 3 key. Control bits are: bit 7 target select (0 means the data memory), bit 4 done flag, bit 2 write enable, bit 1 program start/busy, bit 0 read start. Bits 6, 5 and 3 read 0.
- R2: A control write with bit 0 = 1 and bit 7 = 0 loads the addressed byte into the data register at that same clock edge. Bit 0 always reads back 0.
- R3: The data register keeps its value until another read completes or software writes to select 1.
- R4: A program cycle starts only when a key write of 0x55, then a key write of 0xAA, then a control write with bit 1 = 1 arrive as three consecutive bus accesses.
- R5: Any bus access that is not the next expected key step cancels the key. This covers a wrong key value, a wrong order, a write to another register, and a read of any register.
- R6: Bit 1 can be set only if write enable was already 1 before the control write that sets bit 1. Setting both bits in one write starts nothing.
- R7: Clearing write enable while busy does not abort or alter the program cycle in progress.
- R8: Hardware never changes write enable. Only control writes change it.
- R9: Busy stays high for exactly WRITE_CYCLES clocks after the start edge. Then the byte is stored, busy clears and the done flag (and `done_irq`) becomes 1.
- R10: The done flag stays 1 until a control write with bit 4 = 0. Writing bit 4 = 1 never sets it.
- R11: While busy, read-start and program-start requests are ignored. The program cycle uses the address and data captured at its start, even if software changes those registers afterwards.
- R12: The key register reads 0x00. Memory addresses use only the low ADDR_W bits of the address register (default 6, so 0x45 reaches byte 0x05).
- R13: With bit 7 = 1 in the same control write, neither a read nor a program cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe (counts as an access for the key sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| done_irq | output | 1 | Sticky program-complete flag |

## Verification
The hardest case to reach is a program request that arrives while a program cycle is already running. The checks depend on that request having a valid key and write enable set, so that only the busy guard blocks it. The bench first starts a program cycle, then rewrites the address and data registers, issues a read request and a fully keyed second start request, all inside the busy window. It then reads back both memory locations. That shows the captured address and data were used and that neither later request had any effect.

// File: rtl/keyed_nvm_pkg.sv
package keyed_nvm_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_FIRST = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_BYTE_A = 8'h55;
    localparam logic [7:0] KEY_BYTE_B = 8'hAA;

    localparam int CB_RD   = 0;
    localparam int CB_PROG = 1;
    localparam int CB_WEN  = 2;
    localparam int CB_DONE = 4;
    localparam int CB_TSEL = 7;

    typedef struct packed {
        logic tsel;
        logic keep_done;
        logic wen;
        logic prog;
        logic rd;
    } ctrl_req_t;

    function automatic ctrl_req_t decode_ctrl(input logic [7:0] b);
        ctrl_req_t r;
        r.tsel      = b[CB_TSEL];
        r.keep_done = b[CB_DONE];
        r.wen       = b[CB_WEN];
        r.prog      = b[CB_PROG];
        r.rd        = b[CB_RD];
        return r;
    endfunction

    function automatic logic [7:0] pack_status(input logic tsel, input logic done,
                                               input logic wen, input logic busy);
        logic [7:0] s;
        s = 8'h00;
        s[CB_TSEL] = tsel;
        s[CB_DONE] = done;
        s[CB_WEN]  = wen;
        s[CB_PROG] = busy;
        return s;
    endfunction

endpackage

// File: rtl/keyed_nvm_key_fsm.sv
module keyed_nvm_key_fsm
    import keyed_nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       access,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (access) begin
            if (key_wr && wdata == KEY_BYTE_A) begin
                state_d = KEY_FIRST;
            end else if (key_wr && wdata == KEY_BYTE_B && state_q == KEY_FIRST) begin
                state_d = KEY_ARMED;
            end else begin
                state_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign armed = (state_q == KEY_ARMED);

    // R5
    off_key_access_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !key_wr) |=> (state_q == KEY_IDLE));

    // R4
    armed_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(state_q) == KEY_FIRST && $past(key_wr)));

endmodule

// File: rtl/keyed_nvm_timer.sv
module keyed_nvm_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign finish = busy_q && (cnt_q == '0);
    assign busy   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= LOAD;
            end
        end else if (finish) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> busy);

    // R9
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/keyed_nvm_store.sv
module keyed_nvm_store #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/keyed_nvm_ctrl.sv
module keyed_nvm_ctrl
    import keyed_nvm_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int WRITE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       done_irq
);
    logic [7:0]        addr_q, data_q;
    logic              tsel_q, wen_q, done_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [7:0]        lat_data_q;
    logic [7:0]        cell_rdata;
    logic              busy, finish, armed;
    logic              ctrl_wr, rd_go, prog_go;
    ctrl_req_t         req;

    assign req     = decode_ctrl(bus_wdata);
    assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);
    assign rd_go   = ctrl_wr && req.rd && !req.tsel && !busy;
    assign prog_go = ctrl_wr && req.prog && !req.tsel && wen_q && armed && !busy;

    keyed_nvm_key_fsm u_key (
        .clk   (clk),
        .rst   (rst),
        .access(bus_wr || bus_rd),
        .key_wr(bus_wr && (bus_sel == SEL_KEY)),
        .wdata (bus_wdata),
        .armed (armed)
    );

    keyed_nvm_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (prog_go),
        .busy  (busy),
        .finish(finish)
    );

    keyed_nvm_store #(.ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .we   (finish),
        .waddr(lat_addr_q),
        .wdata(lat_data_q),
        .raddr(addr_q[ADDR_W-1:0]),
        .rdata(cell_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            data_q     <= '0;
            tsel_q     <= 1'b0;
            wen_q      <= 1'b0;
            done_q     <= 1'b0;
            lat_addr_q <= '0;
            lat_data_q <= '0;
        end else begin
            if (bus_wr && bus_sel == SEL_ADDR) addr_q <= bus_wdata;
            if (rd_go) data_q <= cell_rdata;
            else if (bus_wr && bus_sel == SEL_DATA) data_q <= bus_wdata;
            if (ctrl_wr) begin
                tsel_q <= req.tsel;
                wen_q  <= req.wen;
            end
            if (finish) done_q <= 1'b1;
            else if (ctrl_wr && !req.keep_done) done_q <= 1'b0;
            if (prog_go) begin
                lat_addr_q <= addr_q[ADDR_W-1:0];
                lat_data_q <= data_q;
            end
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_sel))
            SEL_ADDR: bus_rdata = addr_q;
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = pack_status(tsel_q, done_q, wen_q, busy);
            SEL_KEY:  bus_rdata = 8'h00;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign done_irq = done_q;

    // R6
    prog_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wen_q) && $past(armed) && $past(ctrl_wr)));

    // R8
    wen_owner_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(wen_q));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !(ctrl_wr && !bus_wdata[CB_DONE])) |=> done_q);

    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(finish));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(lat_addr_q) && $stable(lat_data_q)));

    // R12
    key_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == SEL_KEY) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_keyed_nvm_ctrl.sv
module tb_keyed_nvm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WCYC = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       done_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    keyed_nvm_ctrl #(.ADDR_W(6), .WRITE_CYCLES(WCYC)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_irq(done_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic start_prog(input logic [7:0] a, input logic [7:0] d);
        bus_write(2'd0, a);
        bus_write(2'd1, d);
        bus_write(2'd3, 8'h55);
        bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 4*WCYC && !done_irq; i++) @(posedge clk);
        #1;
    endtask

    task automatic read_cell(input logic [7:0] a, output logic [7:0] v);
        bus_write(2'd0, a);
        bus_write(2'd2, 8'h05);
        bus_read(2'd1, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(2'd0, v); check8("R1 addr after reset", v, 8'h00);
        bus_read(2'd1, v); check8("R1 data after reset", v, 8'h00);
        bus_read(2'd2, v); check8("R1 ctrl after reset", v, 8'h00);
        check8("R1 irq after reset", {7'd0, done_irq}, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        bus_write(2'd2, 8'h04);
        start_prog(8'h05, 8'h3C);
        for (int i = 1; i < WCYC; i++) @(posedge clk);
        #1 check8("R9 irq low one cycle before end", {7'd0, done_irq}, 8'h00);
        @(posedge clk); #1;
        check8("R9 irq high at end", {7'd0, done_irq}, 8'h01);
        bus_read(2'd2, v); check8("R8 R9 ctrl after program", v, 8'h14);
        bus_write(2'd1, 8'h00);
        read_cell(8'h05, v); check8("R2 R4 stored byte", v, 8'h3C);
        bus_read(2'd2, v); check8("R2 read-start bit reads 0", v & 8'h01, 8'h00);
    endtask

    task automatic t_done_flag();
        logic [7:0] v;
        bus_write(2'd2, 8'h14);
        start_prog(8'h06, 8'h61);
        wait_irq();
        bus_write(2'd2, 8'h14);
        check8("R10 flag kept on bit4=1", {7'd0, done_irq}, 8'h01);
        bus_write(2'd2, 8'h04);
        check8("R10 flag cleared on bit4=0", {7'd0, done_irq}, 8'h00);
        bus_write(2'd2, 8'h14);
        check8("R10 bit4=1 does not set flag", {7'd0, done_irq}, 8'h00);
        bus_read(2'd2, v); check8("R10 ctrl readback", v, 8'h04);
    endtask

    task automatic t_bad_keys();
        logic [7:0] v;
        bus_write(2'd2, 8'h04);
        start_prog(8'h10, 8'h42);
        wait_irq();
        bus_write(2'd2, 8'h04);
        bus_write(2'd0, 8'h10);
        bus_write(2'd1, 8'hEE);
        bus_write(2'd3, 8'h55); bus_write(2'd0, 8'h10); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
        bus_read(2'd2, v); check8("R5 other reg write between keys", v, 8'h04);
        bus_write(2'd3, 8'h55); bus_write(2'd3, 8'h5A); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
        bus_read(2'd2, v); check8("R5 wrong key value", v, 8'h04);
        bus_write(2'd3, 8'hAA); bus_write(2'd3, 8'h55);
        bus_write(2'd2, 8'h06);
        bus_read(2'd2, v); check8("R4 reversed key order", v, 8'h04);
        bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA); bus_read(2'd1, v);
        bus_write(2'd2, 8'h06);
        bus_read(2'd2, v); check8("R5 read between key and start", v, 8'h04);
        read_cell(8'h10, v); check8("R5 cell untouched", v, 8'h42);
    endtask

    task automatic t_wen_gate();
        logic [7:0] v;
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
        bus_read(2'd2, v); check8("R6 wen set in same write blocks start", v, 8'h04);
        bus_write(2'd2, 8'h04);
        start_prog(8'h0A, 8'h77);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, v); check8("R7 busy after wen cleared", v, 8'h02);
        wait_irq();
        bus_read(2'd2, v); check8("R7 R8 ctrl after completion", v, 8'h10);
        read_cell(8'h0A, v); check8("R7 byte stored", v, 8'h77);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        bus_write(2'd2, 8'h04);
        start_prog(8'h08, 8'h99);
        wait_irq();
        bus_write(2'd2, 8'h04);
        start_prog(8'h07, 8'h11);
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h22);
        bus_write(2'd2, 8'h05);
        bus_read(2'd1, v); check8("R11 read ignored while busy", v, 8'h22);
        bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h06);
        wait_irq();
        repeat (WCYC + 4) @(posedge clk);
        bus_read(2'd2, v); check8("R11 no second program", v, 8'h14);
        read_cell(8'h07, v); check8("R11 captured addr and data used", v, 8'h11);
        read_cell(8'h08, v); check8("R11 other cell untouched", v, 8'h99);
        bus_write(2'd1, 8'h5A);
        bus_write(2'd0, 8'h07);
        bus_read(2'd1, v); check8("R3 data kept over addr write", v, 8'h5A);
    endtask

    task automatic t_key_mask_tsel();
        logic [7:0] v;
        bus_write(2'd3, 8'h55);
        bus_read(2'd3, v); check8("R12 key reads zero", v, 8'h00);
        read_cell(8'h45, v); check8("R12 address masked", v, 8'h3C);
        bus_write(2'd1, 8'h5A);
        bus_write(2'd0, 8'h05);
        bus_write(2'd2, 8'h81);
        bus_read(2'd1, v); check8("R13 read with target bit ignored", v, 8'h5A);
        bus_write(2'd2, 8'h84);
        bus_write(2'd3, 8'h55); bus_write(2'd3, 8'hAA);
        bus_write(2'd2, 8'h86);
        bus_read(2'd2, v); check8("R13 program with target bit ignored", v, 8'h84);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_basic();
        t_done_flag();
        t_bad_keys();
        t_wen_gate();
        t_busy_ignore();
        t_key_mask_tsel();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule